// File: doc/BRIEF.md
# Constant-Weight Masked Stack Cache

This block is a last-in first-out store that serves a processor as its local data cache. A 32-bit word is pushed in plain form. On its way into the array it is turned into two 32-bit shares. In each share, every data bit sits next to its own inverse, so each share always holds sixteen ones, whatever the data value. Switching activity on the storage bit lines therefore no longer depends on the value being stored.

The reverse step is combinational. The top entry is decoded in the same cycle it is read, so the processor sees an ordinary stack: one push, one pop, or one combined replace per clock, with no stall. Each share pair read from the array is checked for the complement pattern, and an integrity flag is raised if that pattern is broken. The depth is a parameter. A push that does not fit or a pop with nothing to remove leaves the stack as it was and sets a sticky flag.

Top module: `cw_stack_cache`

## Requirements
- R1: After a synchronous active-high reset, empty_o is 1 and full_o, overflow_o and underflow_o are 0.
- R2: For the top entry, top_share_a_o bit 2k equals data bit 2k and bit 2k+1 equals the inverse of data bit 2k, for k = 0..15.
- R3: For the top entry, top_share_b_o bit 2k+1 equals data bit 2k+1 and bit 2k equals the inverse of data bit 2k+1, for k = 0..15.
- R4: Each stored share contains exactly 16 ones for any data value.
- R5: A push of D with pop low, while not full, makes top_data_o equal to D in the next cycle and grows the occupancy by one.
- R6: A pop with push low, while not empty, removes the top entry, so the next cycle shows the entry pushed before it (last in, first out).
- R7: Push and pop together on a non-empty stack replace the top entry with the new word and keep the occupancy unchanged. On an empty stack they act as a push and set underflow_o.
- R8: A push with pop low while full leaves contents and occupancy unchanged and sets overflow_o, which stays set until reset.
- R9: A pop with push low while empty changes nothing and sets underflow_o, which stays set until reset. While empty, top_data_o and both share outputs read 0.
- R10: full_o is 1 exactly when DEPTH entries are held and empty_o is 1 exactly when none are held.
- R11: top_err_o is raised when the top entry fails the complement check (share A bit 2k equal to bit 2k+1, or the same in share B). It never rises for entries written through the push path.
- R12: Any sequence of operations, one per cycle back to back, runs without stall cycles and gives the same result as an unmasked stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | 32 | Plain word to push |
| top_data_o | output | 32 | Decoded top-of-stack word (0 when empty) |
| top_share_a_o | output | 32 | Stored share A of the top entry (0 when empty) |
| top_share_b_o | output | 32 | Stored share B of the top entry (0 when empty) |
| top_err_o | output | 1 | Complement check failed on the top entry |
| empty_o | output | 1 | No entries held |
| full_o | output | 1 | DEPTH entries held |
| overflow_o | output | 1 | Sticky: a push was refused |
| underflow_o | output | 1 | Sticky: a pop was refused |

## Verification
The assertions check on every cycle that each written share has weight 16, that a refused push or pop leaves the occupancy where it was and raises its sticky flag, that the sticky flags never drop, that full and empty never appear together, and that no valid entry fails the complement check. Only the bench scenarios can show the exact bit placement in each share, that the decoded word is correct, the last-in first-out order over a full fill and drain, the replace case, and that long back-to-back mixes of operations match a plain stack model cycle for cycle.

// File: rtl/cwstk_pkg.sv
package cwstk_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t sh_a;
        word_t sh_b;
    } share_pair_t;

    typedef struct packed {
        word_t data;
        logic  bad;
    } decoded_t;

    function automatic share_pair_t cw_encode(input word_t d);
        share_pair_t p;
        for (int k = 0; k < HALF_W; k++) begin
            p.sh_a[2*k]     = d[2*k];
            p.sh_a[2*k+1]   = ~d[2*k];
            p.sh_b[2*k+1]   = d[2*k+1];
            p.sh_b[2*k]     = ~d[2*k+1];
        end
        return p;
    endfunction

    function automatic decoded_t cw_decode(input share_pair_t p);
        decoded_t r;
        r.bad = 1'b0;
        for (int k = 0; k < HALF_W; k++) begin
            r.data[2*k]   = p.sh_a[2*k];
            r.data[2*k+1] = p.sh_b[2*k+1];
            if ((p.sh_a[2*k] == p.sh_a[2*k+1]) || (p.sh_b[2*k] == p.sh_b[2*k+1]))
                r.bad = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/cwstk_encoder.sv
module cwstk_encoder
    import cwstk_pkg::*;
(
    input  word_t       plain_i,
    output share_pair_t shares_o
);
    always_comb shares_o = cw_encode(plain_i);
endmodule

// File: rtl/cwstk_decoder.sv
module cwstk_decoder
    import cwstk_pkg::*;
(
    input  share_pair_t shares_i,
    output word_t       plain_o,
    output logic        bad_o
);
    decoded_t dec;
    always_comb begin
        dec     = cw_decode(shares_i);
        plain_o = dec.data;
        bad_o   = dec.bad;
    end
endmodule

// File: rtl/cwstk_store.sv
module cwstk_store
    import cwstk_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push_i,
    input  logic        pop_i,
    input  share_pair_t wr_word_i,
    output share_pair_t rd_word_o,
    output logic        empty_o,
    output logic        full_o,
    output logic        ovf_o,
    output logic        unf_o
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    share_pair_t     mem [DEPTH];
    logic [CW-1:0]   cnt;
    logic [IW-1:0]   wr_idx, rd_idx;
    logic            grow, shrink, replace, wr_en, refuse_push, refuse_pop;

    always_comb begin
        empty_o     = (cnt == '0);
        full_o      = (cnt == CNT_MAX);
        replace     = push_i && pop_i && !empty_o;
        grow        = push_i && ((!pop_i && !full_o) || (pop_i && empty_o));
        shrink      = pop_i && !push_i && !empty_o;
        refuse_push = push_i && !pop_i && full_o;
        refuse_pop  = pop_i && empty_o;
        wr_en       = grow || replace;
        rd_idx      = IW'(cnt - 1'b1);
        wr_idx      = replace ? rd_idx : IW'(cnt);
        rd_word_o   = mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_word_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else begin
            if (grow)        cnt   <= cnt + 1'b1;
            else if (shrink) cnt   <= cnt - 1'b1;
            if (refuse_push) ovf_o <= 1'b1;
            if (refuse_pop)  unf_o <= 1'b1;
        end
    end

    a_r4_share_weight: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($countones(wr_word_i.sh_a) == HALF_W && $countones(wr_word_i.sh_b) == HALF_W));

    a_r8_full_push_refused: assert property (@(posedge clk) disable iff (rst)
        (full_o && push_i && !pop_i) |=> (full_o && ovf_o));

    a_r9_empty_pop_refused: assert property (@(posedge clk) disable iff (rst)
        (empty_o && pop_i && !push_i) |=> (empty_o && unf_o));

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);

    a_r9_unf_sticky: assert property (@(posedge clk) disable iff (rst)
        unf_o |=> unf_o);

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));

endmodule

// File: rtl/cw_stack_cache.sv
module cw_stack_cache
    import cwstk_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push_i,
    input  logic        pop_i,
    input  logic [31:0] push_data_i,
    output logic [31:0] top_data_o,
    output logic [31:0] top_share_a_o,
    output logic [31:0] top_share_b_o,
    output logic        top_err_o,
    output logic        empty_o,
    output logic        full_o,
    output logic        overflow_o,
    output logic        underflow_o
);
    share_pair_t enc_word, top_word;
    word_t       dec_data;
    logic        dec_bad;

    cwstk_encoder u_enc (
        .plain_i  (push_data_i),
        .shares_o (enc_word)
    );

    cwstk_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .wr_word_i (enc_word),
        .rd_word_o (top_word),
        .empty_o   (empty_o),
        .full_o    (full_o),
        .ovf_o     (overflow_o),
        .unf_o     (underflow_o)
    );

    cwstk_decoder u_dec (
        .shares_i (top_word),
        .plain_o  (dec_data),
        .bad_o    (dec_bad)
    );

    always_comb begin
        top_data_o    = empty_o ? '0 : dec_data;
        top_share_a_o = empty_o ? '0 : top_word.sh_a;
        top_share_b_o = empty_o ? '0 : top_word.sh_b;
        top_err_o     = !empty_o && dec_bad;
    end

    a_r11_valid_entry_clean: assert property (@(posedge clk) disable iff (rst)
        !empty_o |-> !top_err_o);

endmodule

// File: tb/cw_stack_cache_tb.sv
module cw_stack_cache_tb;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic [31:0] push_data_i = '0;
    logic [31:0] top_data_o, top_share_a_o, top_share_b_o;
    logic        top_err_o, empty_o, full_o, overflow_o, underflow_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_mem [DEPTH];
    int          m_cnt = 0;
    logic        m_ovf = 1'b0;
    logic        m_unf = 1'b0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2 clk = ~clk;

    cw_stack_cache #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i),
        .push_data_i(push_data_i), .top_data_o(top_data_o),
        .top_share_a_o(top_share_a_o), .top_share_b_o(top_share_b_o),
        .top_err_o(top_err_o), .empty_o(empty_o), .full_o(full_o),
        .overflow_o(overflow_o), .underflow_o(underflow_o)
    );

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic [31:0] ed, ea, eb;
        ed = (m_cnt > 0) ? m_mem[m_cnt-1] : 32'h0;
        ea = '0; eb = '0;
        if (m_cnt > 0) begin
            for (int k = 0; k < 16; k++) begin
                ea = ea | (32'(ed[2*k]) << (2*k)) | (32'(!ed[2*k]) << (2*k+1));
                eb = eb | (32'(ed[2*k+1]) << (2*k+1)) | (32'(!ed[2*k+1]) << (2*k));
            end
        end
        cmp({req, " R5/R6 top_data"}, top_data_o, ed);
        cmp({req, " R2 share_a"}, top_share_a_o, ea);
        cmp({req, " R3 share_b"}, top_share_b_o, eb);
        if (m_cnt > 0) begin
            cmp({req, " R4 weight_a"}, 32'($countones(top_share_a_o)), 32'd16);
            cmp({req, " R4 weight_b"}, 32'($countones(top_share_b_o)), 32'd16);
        end
        cmp({req, " R10 empty"}, 32'(empty_o), 32'(m_cnt == 0));
        cmp({req, " R10 full"}, 32'(full_o), 32'(m_cnt == DEPTH));
        cmp({req, " R8 overflow"}, 32'(overflow_o), 32'(m_ovf));
        cmp({req, " R9 underflow"}, 32'(underflow_o), 32'(m_unf));
        cmp({req, " R11 err"}, 32'(top_err_o), 32'd0);
    endtask

    task automatic step(input logic p, input logic q, input logic [31:0] d, input string req);
        @(negedge clk);
        push_i = p; pop_i = q; push_data_i = d;
        @(posedge clk);
        #1;
        push_i = 1'b0; pop_i = 1'b0;
        if (p && q) begin
            if (m_cnt > 0) m_mem[m_cnt-1] = d;
            else begin m_mem[0] = d; m_cnt = 1; m_unf = 1'b1; end
        end else if (p) begin
            if (m_cnt == DEPTH) m_ovf = 1'b1;
            else begin m_mem[m_cnt] = d; m_cnt++; end
        end else if (q) begin
            if (m_cnt == 0) m_unf = 1'b1;
            else m_cnt--;
        end
        check_all(req);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        #1; rst = 1'b0;
        m_cnt = 0; m_ovf = 1'b0; m_unf = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        check_all("R1 reset");

        // R5 fill with distinct patterns up to full (R10)
        step(1, 0, 32'h0000_0000, "R5 zero");
        step(1, 0, 32'hFFFF_FFFF, "R5 ones");
        step(1, 0, 32'hAAAA_AAAA, "R5 odd-bits");
        step(1, 0, 32'h5555_5555, "R5 even-bits");
        step(1, 0, 32'hDEAD_BEEF, "R5 mixed");
        step(1, 0, 32'h8000_0001, "R5 ends");
        step(1, 0, 32'h0F0F_F0F0, "R5 nibbles");
        step(1, 0, 32'h1357_9BDF, "R10 fill last");
        // R8 push when full ignored
        step(1, 0, 32'hCAFE_F00D, "R8 push full");
        step(1, 0, 32'h0BAD_0BAD, "R8 push full again");
        // R7 replace on full
        step(1, 1, 32'h2468_ACE0, "R7 replace full");
        // R6 drain in LIFO order
        for (int i = 0; i < DEPTH; i++) step(0, 1, 32'h0, "R6 drain");
        // R9 pop when empty
        step(0, 1, 32'h0, "R9 pop empty");
        // R7 push+pop on empty acts as push
        step(1, 1, 32'h7777_1111, "R7 push-pop empty");
        step(1, 1, 32'h3333_CCCC, "R7 replace single");
        step(0, 1, 32'h0, "R6 pop single");

        // R2 R3 R4 encoding sweep over every byte value
        do_reset();
        check_all("R1 reset again");
        for (int v = 0; v < 256; v++) begin
            step(1, 0, {4{8'(v)}}, "R2 R3 sweep push");
            step(1, 1, {8'(v), 8'(~v), 8'(v ^ 8'h3C), 8'(v + 1)}, "R4 sweep replace");
            step(0, 1, 32'h0, "R6 sweep pop");
        end
        // walking one
        for (int b = 0; b < 32; b++) begin
            step(1, 0, 32'h1 << b, "R2 walk push");
            step(0, 1, 32'h0, "R3 walk pop");
        end

        // R12 back-to-back random mix
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            step(lcg[31], lcg[30] & lcg[29], lcg ^ 32'h9E37_79B9, "R12 mix");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule